// File: doc/BRIEF.md
# Data-Strobe Multispeed Transmit Serializer

The block turns parallel transmit words from a link layer into a serial data-strobe bit pair for a cable port. It runs in one fast clock domain at the highest bit rate, 8 ticks per system cycle. A one-tick pulse, `sys_en_i`, marks each system-clock edge. On that edge the block latches a word, when one is offered, and shifts it out most significant bit first. The speed code sets how many bits are taken from each word: 2, 4 or 8. At the lower speeds each bit is held for 4 or 2 fast ticks, which gives serial rates of 2x, 4x or 8x the system clock.

The serial stream is sent as a data line and a strobe line. The strobe changes state only in bit periods where the data bit repeats, so exactly one of the two lines changes per bit. The data line feeds the B pair driver and the strobe line feeds the A pair driver. An output enable covers the whole packet. Outside a packet both lines are held low.

Top module: `ds_tx_serializer`

## Requirements
- R1: After reset `ds_oe_o`, `ds_data_o` and `ds_strobe_o` are all 0.
- R2: A word on `tx_data_i` is latched only in a cycle where both `sys_en_i` and `tx_valid_i` are 1. Changes on `tx_data_i` in any other cycle have no effect on the serial output.
- R3: The speed code is 2'b00 for the slowest speed, 2'b01 for double speed and 2'b10 for quad speed. Code 2'b11 behaves like 2'b10.
  - At 2'b00 the block sends bits 7 and 6 of each word, each held for 4 fast cycles.
  - At 2'b01 it sends bits 7 down to 4, each held for 2 fast cycles.
  - At 2'b10 it sends bits 7 down to 0, one per fast cycle.
  - In every case the most significant bit goes first.
- R4: `ds_data_o` carries the current bit. `ds_strobe_o` inverts when a new bit equals the previous bit and holds otherwise. As a result, `ds_data_o ^ ds_strobe_o` changes exactly once per bit period and is stable within it.
- R5: A packet starts on a `sys_en_i` cycle with `tx_valid_i` = 1 while no packet is active. That start edge clears the data and strobe history to 0. The first bit appears on the outputs after the next clock edge.
- R6: The speed code is sampled only at packet start. Changes to `speed_i` during a packet are ignored.
- R7: A `sys_en_i` cycle with `tx_valid_i` = 0 ends the packet. Bits of the last word still due at that edge are sent. `ds_oe_o` drops after the following edge, and data and strobe are 0 whenever `ds_oe_o` is 0.
- R8: `tx_valid_i` = 1 without `sys_en_i` neither starts a packet nor changes any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast bit clock (8 ticks per system cycle) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sys_en_i | input | 1 | One-tick pulse marking a system-clock edge |
| speed_i | input | 2 | Speed code (see R3) |
| tx_data_i | input | 8 | Parallel transmit word, upper bits used at lower speeds |
| tx_valid_i | input | 1 | Word valid, sampled with sys_en_i |
| ds_data_o | output | 1 | Encoded data line (B pair) |
| ds_strobe_o | output | 1 | Encoded strobe line (A pair) |
| ds_oe_o | output | 1 | Output enable for the line drivers |

## Verification
The hardest case to reach is the quad-speed word boundary. There, the last bit of one word leaves on the same edge that loads the next word, or that ends the packet. Any off-by-one in load priority or in the end handling corrupts exactly one bit and its strobe.

Directed packets of several words reach this case at every speed, using bit patterns that repeat and alternate across the word seam. The same packets also toggle `speed_i` and `tx_data_i` on the cycles between strobe edges. This shows that neither the mid-packet speed nor the unlatched data leaks into the stream.

// File: rtl/ds_tx_pkg.sv
package ds_tx_pkg;
  localparam int WORD_W  = 8;
  localparam int PHASE_W = $clog2(WORD_W);

  typedef enum logic [1:0] {
    SPD_X1  = 2'd0,
    SPD_X2  = 2'd1,
    SPD_X4  = 2'd2,
    SPD_RSV = 2'd3
  } speed_e;

  // low phase bits that must be zero for a new bit period
  function automatic logic [PHASE_W-1:0] hold_mask(speed_e s);
    case (s)
      SPD_X1:  return PHASE_W'(3);
      SPD_X2:  return PHASE_W'(1);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/ds_tx_phase.sv
module ds_tx_phase
  import ds_tx_pkg::*;
#(
  parameter int PH_W = PHASE_W
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   sys_en_i,
  input  logic   active_i,
  input  speed_e speed_i,
  output logic   bit_en_o
);
  logic [PH_W-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       phase_q <= '0;
    else if (sys_en_i) phase_q <= '0;
    else               phase_q <= phase_q + 1'b1;
  end

  assign bit_en_o = active_i && ((phase_q & PH_W'(hold_mask(speed_i))) == '0);
endmodule

// File: rtl/ds_tx_shifter.sv
module ds_tx_shifter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         shift_i,
  output logic         msb_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (load_i)  sh_q <= data_i;
    else if (shift_i) sh_q <= {sh_q[W-2:0], 1'b0};
  end

  assign msb_o = sh_q[W-1];
endmodule

// File: rtl/ds_tx_encoder.sv
module ds_tx_encoder (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic bit_en_i,
  input  logic active_i,
  input  logic bit_i,
  output logic data_o,
  output logic strobe_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o   <= 1'b0;
      strobe_o <= 1'b0;
    end else if (start_i) begin
      data_o   <= 1'b0;
      strobe_o <= 1'b0;
    end else if (bit_en_i) begin
      data_o   <= bit_i;
      strobe_o <= (bit_i == data_o) ? ~strobe_o : strobe_o;
    end else if (!active_i) begin
      data_o   <= 1'b0;
      strobe_o <= 1'b0;
    end
  end

  assert_ds_toggle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_en_i |=> ((data_o ^ strobe_o) != $past(data_o ^ strobe_o)));

  assert_ds_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !bit_en_i) |=> ($stable(data_o) && $stable(strobe_o)));

  assert_start_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!data_o && !strobe_o));
endmodule

// File: rtl/ds_tx_serializer.sv
module ds_tx_serializer
  import ds_tx_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sys_en_i,
  input  logic [1:0]   speed_i,
  input  logic [W-1:0] tx_data_i,
  input  logic         tx_valid_i,
  output logic         ds_data_o,
  output logic         ds_strobe_o,
  output logic         ds_oe_o
);
  logic   active_q, oe_q, start, load, bit_en, msb;
  speed_e speed_q;

  assign start = sys_en_i && tx_valid_i && !active_q;
  assign load  = sys_en_i && tx_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      speed_q  <= SPD_X1;
      oe_q     <= 1'b0;
    end else begin
      oe_q <= active_q;
      if (sys_en_i) active_q <= tx_valid_i;
      if (start)    speed_q  <= speed_e'(speed_i);
    end
  end

  ds_tx_phase #(.PH_W(PHASE_W)) u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sys_en_i (sys_en_i),
    .active_i (active_q),
    .speed_i  (speed_q),
    .bit_en_o (bit_en)
  );

  ds_tx_shifter #(.W(W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .data_i  (tx_data_i),
    .shift_i (bit_en),
    .msb_o   (msb)
  );

  ds_tx_encoder u_enc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .bit_en_i (bit_en),
    .active_i (active_q),
    .bit_i    (msb),
    .data_o   (ds_data_o),
    .strobe_o (ds_strobe_o)
  );

  assign ds_oe_o = oe_q;

  assert_speed_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |=> $stable(speed_q));

  assert_idle_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ds_oe_o |-> (!ds_data_o && !ds_strobe_o));

  assert_no_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_q && !sys_en_i) |=> !active_q);
endmodule

// File: tb/ds_tx_serializer_bench.sv
module ds_tx_serializer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sys_en = 1'b0;
  logic [1:0] speed = 2'd0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0;
  logic       ds_data, ds_strobe, ds_oe;
  int         n_checks = 0;
  int         n_errors = 0;

  always #4 clk = ~clk;

  ds_tx_serializer u_ds_tx_serializer (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .sys_en_i    (sys_en),
    .speed_i     (speed),
    .tx_data_i   (tx_data),
    .tx_valid_i  (tx_valid),
    .ds_data_o   (ds_data),
    .ds_strobe_o (ds_strobe),
    .ds_oe_o     (ds_oe)
  );

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic chk_outs(input string req, input logic eo, input logic ed, input logic es);
    chk(ds_oe === eo, req, "oe", int'(ds_oe), int'(eo));
    chk(ds_data === ed, req, "data", int'(ds_data), int'(ed));
    chk(ds_strobe === es, req, "strobe", int'(ds_strobe), int'(es));
  endtask

  // R1: reset state
  task automatic test_reset();
    @(negedge clk);
    chk_outs("R1", 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_outs("R1", 1'b0, 1'b0, 1'b0);
  endtask

  // R8: valid without sys_en must not start anything
  task automatic test_valid_no_sys();
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (i > 0) chk_outs("R8", 1'b0, 1'b0, 1'b0);
      sys_en = 1'b0; tx_valid = 1'b1; tx_data = 8'(i * 37);
    end
    @(negedge clk);
    chk_outs("R8", 1'b0, 1'b0, 1'b0);
    tx_valid = 1'b0;
  endtask

  // One packet of n words; speed_i switches to alt from the cycle after start (R6),
  // tx_data_i carries junk off sys_en cycles (R2).
  task automatic send_packet(input logic [1:0] spd, input logic [1:0] alt,
                             input int n, input logic [63:0] words);
    int   div;
    logic pd, ps, ed, es, b;
    div = (spd == 2'd0) ? 4 : (spd == 2'd1) ? 2 : 1;
    pd = 1'b0; ps = 1'b0; ed = 1'b0; es = 1'b0;
    @(negedge clk);
    sys_en = 1'b1; tx_valid = 1'b1; tx_data = words[7:0]; speed = spd;
    for (int m = 1; m <= 8 * n + 2; m++) begin
      @(negedge clk);
      if (m == 1) begin
        chk_outs("R5", 1'b0, 1'b0, 1'b0);
      end else if (m <= 8 * n + 1) begin
        int k;
        k = m - 2;
        if (k % div == 0) begin
          b  = words[(k / 8) * 8 + 7 - (k % 8) / div];
          es = (b == pd) ? ~ps : ps;
          ed = b;
          pd = ed; ps = es;
        end
        chk(ds_oe === 1'b1, "R7", "oe in packet", int'(ds_oe), 1);
        chk(ds_data === ed, "R3", "data bit", int'(ds_data), int'(ed));
        chk(ds_strobe === es, "R4", "strobe", int'(ds_strobe), int'(es));
      end else begin
        chk_outs("R7", 1'b0, 1'b0, 1'b0);
      end
      speed = alt;
      if (m % 8 == 0 && m <= 8 * n) begin
        sys_en   = 1'b1;
        tx_valid = (m / 8 < n);
        tx_data  = (m / 8 < n) ? words[(m / 8) * 8 +: 8] : 8'h5A;
      end else begin
        sys_en   = 1'b0;
        tx_valid = (m <= 8 * n);
        tx_data  = ~tx_data ^ 8'(m);
      end
    end
    sys_en = 1'b0; tx_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk_outs("R7", 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #2_000_000;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    test_reset();
    test_valid_no_sys();
    send_packet(2'd2, 2'd2, 4, 64'h00FF_3CA5);          // R3 quad speed, word seams
    send_packet(2'd2, 2'd2, 2, 64'h0000_0180);          // R4 repeats across seam
    send_packet(2'd1, 2'd1, 4, 64'h0FF0_3CA5);          // R3 double speed
    send_packet(2'd0, 2'd0, 4, 64'hC040_80C0);          // R3 slowest speed
    send_packet(2'd3, 2'd3, 2, 64'h0000_69D2);          // R3 code 3 as quad
    send_packet(2'd0, 2'd2, 3, 64'h0000_4080_C0);       // R6 speed change ignored
    send_packet(2'd2, 2'd0, 3, 64'h0000_00E7_18FF);     // R6 speed change ignored
    send_packet(2'd1, 2'd1, 1, 64'h0000_0000_0000_F0);  // R5 single word, history cleared
    test_valid_no_sys();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule